// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block is a small non-blocking time-division-multiplex switch. Four serial input streams share one frame pulse and one bit clock. Each frame holds 32 byte-wide channels per stream, and each byte is sent most significant bit first. Every input byte is gathered from its serial line and stored in a two-bank data store. Each frame uses the bank that the previous frame did not use. Each of the four serial output streams is built one channel at a time. For every output slot, a routing entry chooses one input stream and channel, or replaces the switched data with a fixed pattern.

A routing entry is held per output stream and channel. It selects between two delay policies. Constant delay keeps a whole frame together by always taking the byte from the previous frame. Variable delay takes the byte from the current frame whenever that byte has already arrived. An entry can also make its slot high impedance, force the slot to all ones, or send a stored message byte. Routing entries are written over a simple write-only register port. A write is staged and then applied together with all other staged writes at a frame boundary, so one frame never mixes old and new routing.

Top module: `tdm_tsi_switch`

## Requirements
- R1: Any output stream and channel can take its byte from any input stream and channel, and several output slots may take the same input byte in the same frame.
- R2: The frame pulse is high during bit period 0 of channel 0. Channel c occupies bit periods 8c to 8c+7 of the 256-period frame, most significant bit first. This timing applies to inputs and outputs alike. The position counter starts at 0 when reset is released, and it is forced back to 0 by every frame pulse.
- R3: With constant delay, output channel c of frame N carries the selected input byte from frame N-1, whatever the two channel numbers are.
- R4: With variable delay, output channel c of frame N carries the selected input byte from frame N if c is greater than the source channel. Otherwise it carries that byte from frame N-1, and this includes output channel 0.
- R5: An entry with its high-impedance bit set drives the stream's enable low for all 8 bit periods of that slot, and its data line high.
- R6: An entry with its force-high bit set drives eight ones with the enable high.
- R7: An entry with its message bit set sends its own message byte with the enable high.
- R8: The entry bits take priority in this order: high impedance first, then force-high, then message, then switched data.
- R9: The routing word is laid out as follows. Bit 18 is high impedance, bit 17 is force-high, bit 16 is message and bit 15 is variable delay. Bits 14:13 are the source stream, bits 12:8 are the source channel and bits 7:0 are the message byte. The address is {output stream[1:0], output channel[4:0]}. A write accepted at frame positions 0 to 253 applies from channel 0 of the next frame. A write at position 254 or 255 applies one frame later.
- R10: Every output enable stays low until the frame that follows the first frame pulse has ended. Output channel 0 of the second frame after that pulse is the first slot that can be driven.
- R11: While reset is asserted, all enables are low and all data lines are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one serial bit per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| framePulse | input | 1 | High in bit period 0 of each frame |
| serIn | input | 4 | Serial input streams |
| cfgWrEn | input | 1 | Routing-entry write strobe |
| cfgAddr | input | 7 | Output stream and channel of the entry |
| cfgWrData | input | 19 | Routing-entry contents |
| serOut | output | 4 | Serial output streams |
| serOe | output | 4 | Per-stream output enable, per bit period |

## Verification
The hardest case to reach from the ports is a byte that is read in the same bit period in which it is being written. This happens when an output slot follows its source slot directly under variable delay. It also happens when output channel 0 takes input channel 31 under constant delay. To reach both, the stimulus programs source channels one position behind the output channel and sets up wrap-around routes. It also places two routing writes at frame positions 253 and 254, so that the deferral at the frame boundary is exercised.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int NUM_STREAMS = 4;
  localparam int NUM_CH      = 32;
  localparam int BYTE_W      = 8;

  localparam int STREAM_W  = $clog2(NUM_STREAMS);
  localparam int CH_W      = $clog2(NUM_CH);
  localparam int BIT_W     = $clog2(BYTE_W);
  localparam int POS_W     = CH_W + BIT_W;
  localparam int FRAME_LEN = NUM_CH * BYTE_W;
  localparam int ADDR_W    = STREAM_W + CH_W;

  // routing entry; field order fixes the register word layout
  typedef struct packed {
    logic                hiZ;
    logic                forceHigh;
    logic                msgMode;
    logic                varDelay;
    logic [STREAM_W-1:0] srcStream;
    logic [CH_W-1:0]     srcCh;
    logic [BYTE_W-1:0]   msgByte;
  } conn_t;

  localparam int CFG_W = $bits(conn_t);

  // strobes from frame control to the datapath
  typedef struct packed {
    logic            bitLast;
    logic            cfgLatch;
    logic            loadValid;
    logic            wrBank;
    logic [CH_W-1:0] curCh;
  } strobe_t;
endpackage

// File: rtl/tsi_frame_ctrl.sv
module tsi_frame_ctrl
  import tsi_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    framePulse,
  output strobe_t strobes
);
  localparam logic [POS_W-1:0] LAST_POS  = POS_W'(FRAME_LEN - 1);
  localparam logic [POS_W-1:0] LATCH_POS = POS_W'(FRAME_LEN - 2);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(BYTE_W - 1);

  logic [POS_W-1:0] posReg;
  logic [POS_W-1:0] pos;
  logic             frameLast;
  logic             started;
  logic             running;
  logic             wrBank;

  assign pos       = framePulse ? '0 : posReg;
  assign frameLast = (pos == LAST_POS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posReg  <= '0;
      started <= 1'b0;
      running <= 1'b0;
      wrBank  <= 1'b0;
    end else begin
      posReg <= frameLast ? '0 : pos + POS_W'(1);
      if (framePulse) started <= 1'b1;
      if (frameLast && started) running <= 1'b1;
      if (frameLast) wrBank <= ~wrBank;
    end
  end

  assign strobes.bitLast   = (pos[BIT_W-1:0] == LAST_BIT);
  assign strobes.cfgLatch  = (pos == LATCH_POS);
  assign strobes.loadValid = frameLast ? started : running;
  assign strobes.wrBank    = wrBank;
  assign strobes.curCh     = pos[POS_W-1:BIT_W];

  // R10
  run_after_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(running) |-> $past(frameLast) && $past(started));

  // R10
  no_early_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    !started && !framePulse |-> !strobes.loadValid);

  // R3
  bank_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrBank != $past(wrBank)) |-> $past(frameLast));
endmodule

// File: rtl/tsi_switch_dp.sv
module tsi_switch_dp
  import tsi_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                strobes,
  input  logic [NUM_STREAMS-1:0] serIn,
  input  logic                   cfgWrEn,
  input  logic [ADDR_W-1:0]      cfgAddr,
  input  logic [CFG_W-1:0]       cfgWrData,
  output logic [NUM_STREAMS-1:0] serOut,
  output logic [NUM_STREAMS-1:0] serOe
);
  logic [BYTE_W-2:0] inShift [NUM_STREAMS];
  logic [BYTE_W-1:0] inByte  [NUM_STREAMS];
  logic [BYTE_W-1:0] dataMem [2][NUM_STREAMS][NUM_CH];
  conn_t             connPend [NUM_STREAMS][NUM_CH];
  conn_t             connAct  [NUM_STREAMS][NUM_CH];

  // serial to parallel
  always_comb begin
    for (int s = 0; s < NUM_STREAMS; s++) inByte[s] = {inShift[s], serIn[s]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_STREAMS; s++) inShift[s] <= '0;
    end else begin
      for (int s = 0; s < NUM_STREAMS; s++) inShift[s] <= inByte[s][BYTE_W-2:0];
    end
  end

  // two-bank data store, one bank per frame parity
  always_ff @(posedge clk) begin
    if (strobes.bitLast) begin
      for (int s = 0; s < NUM_STREAMS; s++)
        dataMem[strobes.wrBank][s][strobes.curCh] <= inByte[s];
    end
  end

  // staged and active routing entries
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_STREAMS; s++)
        for (int c = 0; c < NUM_CH; c++) begin
          connPend[s][c] <= '0;
          connAct[s][c]  <= '0;
        end
    end else begin
      if (strobes.cfgLatch) connAct <= connPend;
      if (cfgWrEn) connPend[cfgAddr[ADDR_W-1:CH_W]][cfgAddr[CH_W-1:0]] <= conn_t'(cfgWrData);
    end
  end

  logic [CH_W-1:0] nextCh;
  assign nextCh = strobes.curCh + CH_W'(1);

  for (genvar o = 0; o < NUM_STREAMS; o++) begin : g_out
    conn_t             ent;
    logic              sameFrame;
    logic              rdBank;
    logic              fwd;
    logic [BYTE_W-1:0] swByte;
    logic [BYTE_W-1:0] selByte;
    logic              selOe;
    logic [BYTE_W-1:0] outShift;
    logic              outOe;

    assign ent = connAct[o][nextCh];

    always_comb begin
      sameFrame = ent.varDelay && (nextCh > ent.srcCh);
      rdBank    = (sameFrame || nextCh == '0) ? strobes.wrBank : ~strobes.wrBank;
      fwd       = (rdBank == strobes.wrBank) && (ent.srcCh == strobes.curCh);
      swByte    = fwd ? inByte[ent.srcStream] : dataMem[rdBank][ent.srcStream][ent.srcCh];
      selOe     = 1'b1;
      selByte   = swByte;
      if (!strobes.loadValid || ent.hiZ) begin
        selOe   = 1'b0;
        selByte = '1;
      end else if (ent.forceHigh) begin
        selByte = '1;
      end else if (ent.msgMode) begin
        selByte = ent.msgByte;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        outShift <= '1;
        outOe    <= 1'b0;
      end else if (strobes.bitLast) begin
        outShift <= selByte;
        outOe    <= selOe;
      end else begin
        outShift <= {outShift[BYTE_W-2:0], 1'b1};
      end
    end

    assign serOut[o] = outShift[BYTE_W-1];
    assign serOe[o]  = outOe;

    // R5
    hiz_idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
      !serOe[o] |-> serOut[o]);

    // R2
    oe_slot_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
      !$past(strobes.bitLast) |-> $stable(serOe[o]));

    // R6
    force_high_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobes.bitLast && strobes.loadValid && ent.forceHigh && !ent.hiZ
        |=> serOe[o] && serOut[o]);
  end
endmodule

// File: rtl/tdm_tsi_switch.sv
module tdm_tsi_switch
  import tsi_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   framePulse,
  input  logic [NUM_STREAMS-1:0] serIn,
  input  logic                   cfgWrEn,
  input  logic [ADDR_W-1:0]      cfgAddr,
  input  logic [CFG_W-1:0]       cfgWrData,
  output logic [NUM_STREAMS-1:0] serOut,
  output logic [NUM_STREAMS-1:0] serOe
);
  strobe_t strobes;

  tsi_frame_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .framePulse (framePulse),
    .strobes    (strobes)
  );

  tsi_switch_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .serIn     (serIn),
    .cfgWrEn   (cfgWrEn),
    .cfgAddr   (cfgAddr),
    .cfgWrData (cfgWrData),
    .serOut    (serOut),
    .serOe     (serOe)
  );
endmodule

// File: tb/tdm_tsi_switch_tb.sv
module tdm_tsi_switch_tb;
  localparam int NS = 4;
  localparam int NC = 32;
  localparam int FL = 256;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          framePulse = 1'b0;
  logic [NS-1:0] serIn = '0;
  logic          cfgWrEn = 1'b0;
  logic [6:0]    cfgAddr = '0;
  logic [18:0]   cfgWrData = '0;
  logic [NS-1:0] serOut;
  logic [NS-1:0] serOe;

  int  tcyc = 0;
  int  errors = 0;
  int  checks = 0;
  bit  done = 1'b0;

  logic [18:0] pendM [NS][NC];
  logic [18:0] actM  [NS][NC];
  logic [18:0] frmM  [NS][NC];

  always #2.5 clk = ~clk;

  tdm_tsi_switch u_dut (
    .clk(clk), .rstN(rstN), .framePulse(framePulse), .serIn(serIn),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .serOut(serOut), .serOe(serOe)
  );

  function automatic logic [7:0] byteOf(int f, int s, int c);
    int v;
    v = f * 73 + s * 151 + c * 29 + f * c * (s + 1);
    return 8'(v ^ (v >> 3) ^ (c << 4));
  endfunction

  function automatic logic [18:0] mk(bit hz, bit fh, bit mm, bit vd, int ss, int sc, int mb);
    return {hz, fh, mm, vd, 2'(ss), 5'(sc), 8'(mb)};
  endfunction

  initial begin
    for (int s = 0; s < NS; s++)
      for (int c = 0; c < NC; c++) begin
        pendM[s][c] = '0; actM[s][c] = '0; frmM[s][c] = '0;
      end
  end

  // behavioural reference of the routing-entry staging (R9)
  always @(posedge clk) begin
    if (rstN) begin
      if (tcyc % FL == FL - 2) actM = pendM;
      if (cfgWrEn) pendM[cfgAddr[6:5]][cfgAddr[4:0]] = cfgWrData;
      if (tcyc % FL == FL - 1) frmM = actM;
      tcyc++;
    end
  end

  // compare the outputs in the middle of each cycle, then drive that cycle's inputs
  always @(negedge clk) begin
    if (rstN && !done) begin
      int f, p, c, k;
      string phase;
      f = tcyc / FL; p = tcyc % FL; c = p / 8; k = p % 8;
      if (f < 2)      phase = "R10 startup";
      else if (f < 4) phase = "R1 R2 R3 routing";
      else if (f < 6) phase = "R4 R5 R6 R7 R8 modes";
      else            phase = "R9 cfg timing";
      for (int o = 0; o < NS; o++) begin
        logic expOe, expOut;
        string tag;
        logic [18:0] e;
        logic [7:0] b;
        e = frmM[o][c];
        if (f < 2) begin
          expOe = 1'b0; expOut = 1'b1; tag = "R10";
        end else begin
          int nset;
          nset = int'(e[18]) + int'(e[17]) + int'(e[16]);
          tag = (nset > 1) ? "R8" : e[18] ? "R5" : e[17] ? "R6" : e[16] ? "R7" :
                e[15] ? "R4" : "R3";
          if (e[18]) begin
            expOe = 1'b0; expOut = 1'b1;
          end else begin
            expOe = 1'b1;
            if (e[17]) b = 8'hFF;
            else if (e[16]) b = e[7:0];
            else if (e[15] && c > int'(e[12:8])) b = byteOf(f, int'(e[14:13]), int'(e[12:8]));
            else b = byteOf(f - 1, int'(e[14:13]), int'(e[12:8]));
            expOut = b[7 - k];
          end
        end
        checks++;
        if (serOe[o] !== expOe || serOut[o] !== expOut) begin
          errors++;
          $display("FAIL %s [%s] stream %0d cycle %0d: got oe=%b out=%b, expected oe=%b out=%b",
                   tag, phase, o, tcyc, serOe[o], serOut[o], expOe, expOut);
        end
      end
    end
    // drive inputs for the current cycle (R2 framing)
    begin
      int f, p;
      f = tcyc / FL; p = tcyc % FL;
      framePulse <= (p == 0 && tcyc >= FL);
      for (int s = 0; s < NS; s++) serIn[s] <= byteOf(f, s, p / 8)[7 - (p % 8)];
    end
  end

  task automatic writeCfg(int o, int c, logic [18:0] d);
    cfgWrEn = 1'b1; cfgAddr = {2'(o), 5'(c)}; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic waitCyc(int n);
    while (tcyc < n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    checks++;
    if (serOe !== 4'h0) begin
      errors++; $display("FAIL R11 reset enable: got %b expected 0000", serOe);
    end
    checks++;
    if (serOut !== 4'hF) begin
      errors++; $display("FAIL R11 reset data: got %b expected 1111", serOut);
    end
    rstN = 1'b1;

    // R1 R3: full permutation, constant delay, written in frame 0
    waitCyc(2);
    for (int o = 0; o < NS; o++)
      for (int c = 0; c < NC; c++)
        writeCfg(o, c, mk(0, 0, 0, 0, (o + 1) % NS, (c * 7 + 3) % NC, 0));

    // frame 3: modes, variable delay and broadcast
    waitCyc(3 * FL + 10);
    for (int c = 0; c < NC; c++) begin
      int ic;
      ic = (c % 4 == 3) ? (c + 5) % NC : (c - c % 3);
      writeCfg(0, c, mk(0, 0, 0, 1, 2, ic, 0));          // R4 incl. adjacent slot
    end
    writeCfg(0, 0, mk(0, 0, 0, 1, 1, 31, 0));             // R4 channel 0 from last slot
    for (int c = 0; c < NC; c++) begin
      case (c % 5)
        0: writeCfg(1, c, mk(1, 0, 0, 0, 3, c, 0));                 // R5
        1: writeCfg(1, c, mk(0, 1, 0, 0, 3, c, 0));                 // R6
        2: writeCfg(1, c, mk(0, 0, 1, 0, 3, c, c * 9 + 1));         // R7
        3: writeCfg(1, c, mk(1, 1, 1, 0, 3, c, 8'h3C));             // R8
        default: writeCfg(1, c, mk(0, 1, 1, 1, 3, c, 8'h00));       // R8
      endcase
    end
    for (int c = 0; c < NC; c++)                                       // R1 broadcast
      writeCfg(2, c, (c % 2 == 0) ? mk(0, 0, 0, 0, 1, 9, 0) : mk(0, 0, 0, 0, 0, NC - c, 0));
    writeCfg(3, 0, mk(0, 0, 0, 0, 0, 31, 0));             // R3 channel 0 from slot 31

    // R9: writes at positions 253 and 254 land one frame apart
    waitCyc(5 * FL + FL - 3);
    writeCfg(3, 6, mk(0, 0, 1, 0, 0, 0, 8'hA5));
    writeCfg(3, 5, mk(0, 0, 1, 0, 0, 0, 8'h5A));

    waitCyc(9 * FL);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL R10 watchdog: got cycle %0d expected end by %0d", tcyc, 9 * FL);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule